// File: doc/BRIEF.md
# Single-Bus Multi-Cycle Instruction Sequencer

This block is a compact 16-bit execution core. All internal transfers pass over one shared bus. Its storage is:

- a program counter;
- an address holding register and a data holding register for memory;
- an instruction register;
- eight general registers, with two operand read ports and one write port;
- three mutually exclusive result flags: negative, zero and positive.

Only one gated source may place a value on the bus in a given cycle. The sources are the program counter, the data holding register and the ALU output. A register takes the bus value only on a clock edge where its own load is asserted.

A control state machine runs every instruction through the same three fetch cycles:

1. The address register takes the program counter, and the program counter advances by one.
2. The data register takes the memory word.
3. The instruction register takes the data register.

The opcode is examined by the next-state logic during the third fetch cycle, so decoding costs no cycle. A recognised instruction then spends exactly one execute cycle. In that cycle the ALU result is gated onto the bus, written into the destination register and used to load the flags. Words that are not recognised send the machine straight back to fetch.

The memory port reads one word per cycle: the word addressed by `mem_addr` must be present on `mem_rdata` in the cycle that `mem_en` is high. A side read port (`dbg_rsel`/`dbg_rdata`) and the `dbg_pc`, `dbg_ir` and `dbg_flags` outputs expose architectural state for observation.

Top module: `bus_seq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, the instruction register and all eight general registers become 0, and the flags become zero-only (`dbg_flags` = 3'b010, bit order N,Z,P).
- R2: Each instruction performs exactly one memory read. `mem_en` is high for a single cycle, with `mem_addr` equal to that instruction's address and `mem_we` low. The PC advances by one during the first fetch cycle.
- R3: After fetch, `dbg_ir` holds the word read from memory at the fetched address.
- R4: Opcode `IR[15:12]`=4'b1001 writes the bitwise inverse of register `IR[8:6]` into register `IR[11:9]`.
- R5: Opcode 4'b0001 with `IR[5]`=0 writes the sum modulo 2^16 of registers `IR[8:6]` and `IR[2:0]` into register `IR[11:9]`.
- R6: Opcode 4'b0101 with `IR[5]`=0 writes the bitwise AND of registers `IR[8:6]` and `IR[2:0]` into register `IR[11:9]`.
- R7: Every executed instruction loads the flags from its result: N when bit 15 is set, Z when the result is zero, P otherwise. Exactly one flag is set at all times after reset.
- R8: Any other opcode, or `IR[5]`=1 with ADD or AND, changes no general register and no flag.
- R9: A recognised instruction takes four cycles from one memory read to the next. An ignored instruction takes three.
- R10: In every cycle, at most one of the three bus sources drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe (always low; reads only) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data (data holding register) |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| dbg_rsel | input | 3 | General register index for observation |
| dbg_rdata | output | DW | Value of the selected general register |
| dbg_pc | output | AW | Program counter |
| dbg_ir | output | DW | Instruction register |
| dbg_flags | output | 3 | Flags {N,Z,P} |

## Verification
The bench builds the core with its default widths: 16-bit data, 16-bit addresses and eight registers. With these widths, 0xFFFF+0x0001 wraps to zero and sign-bit flag cases can be produced by short programs. It uses a 64-word memory model, which puts every program's instruction words and the unused zero-opcode words within reach. Directed programs chain NOT, ADD and AND results so that each flag value, an overflowing sum and both ignored-instruction forms occur. A log of memory-read cycles measures the four-cycle and three-cycle instruction lengths.

// File: rtl/bus_seq_core.sv
module bus_seq_core #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [2:0]    dbg_rsel,
  output logic [DW-1:0] dbg_rdata,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_ir,
  output logic [2:0]    dbg_flags
);
  localparam int RW = $clog2(NREG);
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;

  typedef enum logic [1:0] {ST_ADDR, ST_READ, ST_LATCH, ST_EXEC} step_t;
  step_t state, nstate;

  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir, bus, alu, opa, opb;
  logic [DW-1:0] regs [NREG];
  logic [2:0]    flags;

  logic gate_pc, gate_mdr, gate_alu;
  logic ld_mar, ld_pc, ld_mdr, ld_ir, ld_reg, ld_cc;

  function automatic logic known_op(input logic [DW-1:0] w);
    return (w[15:12] == OP_NOT) ||
           ((w[15:12] == OP_ADD || w[15:12] == OP_AND) && !w[5]);
  endfunction

  assign gate_pc  = (state == ST_ADDR);
  assign ld_mar   = (state == ST_ADDR);
  assign ld_pc    = (state == ST_ADDR);
  assign ld_mdr   = (state == ST_READ);
  assign gate_mdr = (state == ST_LATCH);
  assign ld_ir    = (state == ST_LATCH);
  assign gate_alu = (state == ST_EXEC);
  assign ld_reg   = (state == ST_EXEC);
  assign ld_cc    = (state == ST_EXEC);

  always_comb begin
    case (state)
      ST_ADDR:  nstate = ST_READ;
      ST_READ:  nstate = ST_LATCH;
      ST_LATCH: nstate = known_op(bus) ? ST_EXEC : ST_ADDR;
      default:  nstate = ST_ADDR;
    endcase
  end

  assign opa = regs[ir[8:6]];
  assign opb = regs[ir[2:0]];

  always_comb begin
    case (ir[15:12])
      OP_ADD:  alu = opa + opb;
      OP_AND:  alu = opa & opb;
      default: alu = ~opa;
    endcase
  end

  always_comb begin
    if (gate_pc)       bus = DW'(pc);
    else if (gate_mdr) bus = mdr;
    else if (gate_alu) bus = alu;
    else               bus = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ADDR;
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir    <= '0;
      flags <= 3'b010;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      state <= nstate;
      if (ld_mar) mar <= AW'(bus);
      if (ld_pc)  pc  <= pc + 1'b1;
      if (ld_mdr) mdr <= mem_rdata;
      if (ld_ir)  ir  <= bus;
      if (ld_reg) regs[ir[11:9]] <= bus;
      if (ld_cc)  flags <= {bus[DW-1], bus == '0, !bus[DW-1] && bus != '0};
    end
  end

  assign mem_en    = (state == ST_READ);
  assign mem_we    = 1'b0;
  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign dbg_rdata = regs[RW'(dbg_rsel)];
  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_flags = flags;
endmodule

// File: rtl/bus_seq_core_chk.sv
module bus_seq_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          gate_pc,
  input logic          gate_mdr,
  input logic          gate_alu,
  input logic          mem_en,
  input logic          ld_cc,
  input logic [AW-1:0] pc,
  input logic [2:0]    flags
);
  a_r10_one_bus_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_pc, gate_mdr, gate_alu}));

  a_r7_one_flag: assert property (@(posedge clk) disable iff (rst)
    $countones(flags) == 1);

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_cc |=> $stable(flags));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    gate_pc |=> pc == $past(pc) + 1'b1);

  a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  a_r9_exec_then_fetch: assert property (@(posedge clk) disable iff (rst)
    gate_alu |=> gate_pc);
endmodule

bind bus_seq_core bus_seq_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .gate_pc(gate_pc), .gate_mdr(gate_mdr),
  .gate_alu(gate_alu), .mem_en(mem_en), .ld_cc(ld_cc), .pc(pc), .flags(flags)
);

// File: tb/sim_bus_seq_core.sv
`timescale 1ns/1ps
module sim_bus_seq_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  dbg_rsel = 3'd0;
  logic [15:0] dbg_rdata, dbg_pc, dbg_ir;
  logic [2:0]  dbg_flags;

  logic [15:0] mem [64];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nlog = 0;
  int log_cyc [8];
  logic [15:0] log_addr [8];
  logic        log_we [8];

  always #2 clk = ~clk;

  bus_seq_core u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_rsel(dbg_rsel), .dbg_rdata(dbg_rdata), .dbg_pc(dbg_pc),
    .dbg_ir(dbg_ir), .dbg_flags(dbg_flags)
  );

  assign mem_rdata = mem[mem_addr[5:0]];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  always @(negedge clk) begin
    if (!rst && mem_en && nlog < 8) begin
      log_cyc[nlog]  = cyc;
      log_addr[nlog] = mem_addr;
      log_we[nlog]   = mem_we;
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_is(input string req, input int idx, input logic [15:0] exp);
    dbg_rsel = 3'(idx);
    #1;
    chk(req, dbg_rdata, exp);
  endtask

  task automatic restart();
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    rst = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic release_rst();
    @(negedge clk);
    nlog = 0;
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    restart();
    @(negedge clk);
    chk("R1 pc", dbg_pc, 16'h0000);
    chk("R1 ir", dbg_ir, 16'h0000);
    chk("R1 flags", {13'd0, dbg_flags}, 16'h0002);
    for (int r = 0; r < 8; r++) reg_is("R1 reg", r, 16'h0000);
    release_rst();
  endtask

  task automatic t_not();
    restart();
    mem[0] = 16'h927F;
    mem[1] = 16'h947F;
    release_rst();
    run(4);
    chk("R3 ir", dbg_ir, 16'h927F);
    chk("R2 pc", dbg_pc, 16'h0001);
    reg_is("R4 not r1", 1, 16'hFFFF);
    chk("R7 N flag", {13'd0, dbg_flags}, 16'h0004);
    run(4);
    reg_is("R4 not r2", 2, 16'h0000);
    reg_is("R4 r1 kept", 1, 16'hFFFF);
    chk("R7 Z flag", {13'd0, dbg_flags}, 16'h0002);
  endtask

  task automatic t_add();
    restart();
    mem[0] = 16'h927F;
    mem[1] = 16'h1441;
    mem[2] = 16'h96BF;
    mem[3] = 16'h1A43;
    mem[4] = 16'h1EC3;
    release_rst();
    run(8);
    reg_is("R5 add neg", 2, 16'hFFFE);
    chk("R7 N after add", {13'd0, dbg_flags}, 16'h0004);
    run(4);
    reg_is("R4 not small", 3, 16'h0001);
    chk("R7 P flag", {13'd0, dbg_flags}, 16'h0001);
    run(4);
    reg_is("R5 add wrap", 5, 16'h0000);
    chk("R7 Z after wrap", {13'd0, dbg_flags}, 16'h0002);
    run(4);
    reg_is("R5 add same src", 7, 16'h0002);
    chk("R7 P after add", {13'd0, dbg_flags}, 16'h0001);
  endtask

  task automatic t_and();
    restart();
    mem[0] = 16'h927F;
    mem[1] = 16'h1441;
    mem[2] = 16'h96BF;
    mem[3] = 16'h58C2;
    mem[4] = 16'h5042;
    mem[5] = 16'h5CC1;
    release_rst();
    run(16);
    reg_is("R6 and zero", 4, 16'h0000);
    chk("R7 Z after and", {13'd0, dbg_flags}, 16'h0002);
    run(4);
    reg_is("R6 and into r0", 0, 16'hFFFE);
    chk("R7 N after and", {13'd0, dbg_flags}, 16'h0004);
    run(4);
    reg_is("R6 and one", 6, 16'h0001);
    chk("R7 P after and", {13'd0, dbg_flags}, 16'h0001);
  endtask

  task automatic t_ignored();
    restart();
    mem[0] = 16'h927F;
    mem[1] = 16'hF025;
    mem[2] = 16'h1CE1;
    release_rst();
    run(7);
    chk("R8 ir undefined", dbg_ir, 16'hF025);
    chk("R8 pc undefined", dbg_pc, 16'h0002);
    chk("R8 flags undefined", {13'd0, dbg_flags}, 16'h0004);
    run(3);
    chk("R8 ir imm form", dbg_ir, 16'h1CE1);
    chk("R8 flags imm form", {13'd0, dbg_flags}, 16'h0004);
    reg_is("R8 r6 untouched", 6, 16'h0000);
    reg_is("R8 r1 kept", 1, 16'hFFFF);
    for (int r = 2; r < 8; r++) reg_is("R8 reg untouched", r, 16'h0000);
  endtask

  task automatic t_timing();
    restart();
    mem[0] = 16'h927F;
    mem[1] = 16'hF025;
    mem[2] = 16'h947F;
    release_rst();
    run(13);
    chk("R2 read count", 16'(nlog), 16'd4);
    for (int k = 0; k < 4; k++) begin
      chk("R2 read addr", log_addr[k], 16'(k));
      chk("R2 read only", {15'd0, log_we[k]}, 16'd0);
    end
    chk("R9 valid interval", 16'(log_cyc[1] - log_cyc[0]), 16'd4);
    chk("R9 ignored interval", 16'(log_cyc[2] - log_cyc[1]), 16'd3);
    chk("R9 next interval", 16'(log_cyc[3] - log_cyc[2]), 16'd4);
    chk("R10 bus value via not", {13'd0, dbg_flags}, 16'h0002);
  endtask

  initial begin
    #(20000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_not();
    t_add();
    t_and();
    t_ignored();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule